// File: doc/BRIEF.md
# Move-Instruction Decoder with Destination Prefix

This block decodes the fixed 16-bit instruction words of a transport-triggered, accumulator-based core. In this core every operation is a transfer from a source to a destination register. It takes one instruction word per cycle, qualified by `instr_valid`. One cycle later it presents the decoded transfer on registered outputs, with a single-cycle `move_valid` strobe.

The source is either an immediate byte or a module/index register pair. The destination is always a module/index pair. The destination field of a word holds only three index bits, but each module has 32 registers. To reach the upper 24 registers of a module, the word must be preceded by a write to a prefix register. That write costs one extra cycle. It loads two high-order index bits and applies to the next accepted word only.

Top module: `move_decoder`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `move_valid` is 0, every decoded output is zero and any pending prefix is discarded.
- R2: An accepted word with bit 15 = 0 is an immediate transfer. In the cycle after acceptance, `src_is_imm` is 1 and `src_imm` equals bits 7:0.
- R3: An accepted word with bit 15 = 1 is a register transfer. In the cycle after acceptance, `src_is_imm` is 0, `src_mod` equals bits 3:0 and `src_idx` equals bits 7:4. `src_imm` carries bits 7:0 in both formats.
- R4: `dst_mod` equals bits 11:8, and `dst_idx[2:0]` equals bits 14:12. With no pending prefix, `dst_idx[4:3]` is 0.
- R5: A word whose bits 14:8 equal 7'h0B (module 4'hB, subindex 0) is a prefix write. It loads the prefix from bits 1:0 of the word, in either source format, and produces no `move_valid` strobe.
- R6: The next accepted non-prefix word after a prefix write gets `dst_idx[4:3]` equal to the prefix value. The prefix then returns to 0, so the word after that has `dst_idx[4:3]` = 0.
- R7: When two prefix writes are accepted back to back, the later value is the one applied.
- R8: Cycles with `instr_valid` low produce no strobe and do not consume a pending prefix.
- R9: Each accepted non-prefix word raises `move_valid` for exactly the following cycle. Consecutive accepted words give consecutive strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word present this cycle |
| instr | input | 16 | Instruction word |
| move_valid | output | 1 | Decoded transfer on outputs this cycle |
| src_is_imm | output | 1 | Source is the immediate byte |
| src_imm | output | 8 | Immediate byte (bits 7:0 of the word) |
| src_mod | output | 4 | Source module specifier |
| src_idx | output | 4 | Source register index |
| dst_mod | output | 4 | Destination module specifier |
| dst_idx | output | 5 | Destination register index including prefix bits |

## Verification
The embedded assertions check the following on every cycle:
- no strobe follows a prefix write or an idle cycle, and a strobe always follows an accepted ordinary word;
- the prefix is empty after it is used;
- the immediate byte and format flag follow the accepted word;
- the upper destination bits stay zero when no prefix is pending.

Only the bench scenarios can show the specific index values that result from a prefix, including the case where a later back-to-back prefix wins. The same holds for a prefix surviving idle gaps, a prefix written with a register-format word, and reset discarding a pending prefix.

// File: rtl/move_decoder_pkg.sv
package move_decoder_pkg;
  localparam int INSTR_W = 16;
  localparam int IMM_W   = 8;
  localparam int MOD_W   = 4;
  localparam int SIDX_W  = 4;
  localparam int SUB_W   = 3;
  localparam int PFX_W   = 2;
  localparam int DIDX_W  = SUB_W + PFX_W;

  typedef struct packed {
    logic              is_imm;
    logic [IMM_W-1:0]  imm;
    logic [MOD_W-1:0]  s_mod;
    logic [SIDX_W-1:0] s_idx;
    logic [MOD_W-1:0]  d_mod;
    logic [SUB_W-1:0]  d_sub;
  } move_fields_t;
endpackage

// File: rtl/move_field_split.sv
module move_field_split
  import move_decoder_pkg::*;
#(
  parameter logic [MOD_W-1:0] PFX_MOD = 4'hB,
  parameter logic [SUB_W-1:0] PFX_SUB = 3'd0
) (
  input  logic [INSTR_W-1:0] instr,
  output move_fields_t       fields,
  output logic               is_pfx,
  output logic [PFX_W-1:0]   pfx_val
);
  localparam int SMOD_LO = 0;
  localparam int SIDX_LO = SMOD_LO + MOD_W;
  localparam int DMOD_LO = IMM_W;
  localparam int DSUB_LO = DMOD_LO + MOD_W;

  always_comb begin
    fields.is_imm = ~instr[INSTR_W-1];
    fields.imm    = instr[IMM_W-1:0];
    fields.s_mod  = instr[SMOD_LO +: MOD_W];
    fields.s_idx  = instr[SIDX_LO +: SIDX_W];
    fields.d_mod  = instr[DMOD_LO +: MOD_W];
    fields.d_sub  = instr[DSUB_LO +: SUB_W];
    is_pfx        = (fields.d_mod == PFX_MOD) && (fields.d_sub == PFX_SUB);
    pfx_val       = instr[PFX_W-1:0];
  end
endmodule

// File: rtl/move_prefix_reg.sv
module move_prefix_reg
  import move_decoder_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             consume,
  input  logic [PFX_W-1:0] load_val,
  output logic [PFX_W-1:0] pfx_q
);
  always_ff @(posedge clk) begin
    if (rst)          pfx_q <= '0;
    else if (load)    pfx_q <= load_val;
    else if (consume) pfx_q <= '0;
  end

  // R6: prefix is empty after an ordinary word uses it
  a_r6_prefix_spent: assert property (@(posedge clk) disable iff (rst)
    (consume && !load) |=> (pfx_q == '0));

  // R7: the latest prefix write is the one held
  a_r7_latest_prefix: assert property (@(posedge clk) disable iff (rst)
    load |=> (pfx_q == $past(load_val)));

  // R8: idle cycles keep a pending prefix
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!load && !consume) |=> $stable(pfx_q));
endmodule

// File: rtl/move_decoder.sv
module move_decoder
  import move_decoder_pkg::*;
#(
  parameter logic [MOD_W-1:0] PFX_MOD = 4'hB,
  parameter logic [SUB_W-1:0] PFX_SUB = 3'd0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                instr_valid,
  input  logic [INSTR_W-1:0]  instr,
  output logic                move_valid,
  output logic                src_is_imm,
  output logic [IMM_W-1:0]    src_imm,
  output logic [MOD_W-1:0]    src_mod,
  output logic [SIDX_W-1:0]   src_idx,
  output logic [MOD_W-1:0]    dst_mod,
  output logic [DIDX_W-1:0]   dst_idx
);
  move_fields_t     fields;
  logic             is_pfx;
  logic [PFX_W-1:0] pfx_val;
  logic [PFX_W-1:0] pfx_q;
  logic             pfx_load;
  logic             move_take;

  move_field_split #(.PFX_MOD(PFX_MOD), .PFX_SUB(PFX_SUB)) i_split (
    .instr   (instr),
    .fields  (fields),
    .is_pfx  (is_pfx),
    .pfx_val (pfx_val)
  );

  assign pfx_load  = instr_valid && is_pfx;
  assign move_take = instr_valid && !is_pfx;

  move_prefix_reg i_prefix (
    .clk      (clk),
    .rst      (rst),
    .load     (pfx_load),
    .consume  (move_take),
    .load_val (pfx_val),
    .pfx_q    (pfx_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      move_valid <= 1'b0;
      src_is_imm <= 1'b0;
      src_imm    <= '0;
      src_mod    <= '0;
      src_idx    <= '0;
      dst_mod    <= '0;
      dst_idx    <= '0;
    end else begin
      move_valid <= move_take;
      if (move_take) begin
        src_is_imm <= fields.is_imm;
        src_imm    <= fields.imm;
        src_mod    <= fields.s_mod;
        src_idx    <= fields.s_idx;
        dst_mod    <= fields.d_mod;
        dst_idx    <= {pfx_q, fields.d_sub};
      end
    end
  end

  // R5: a prefix write makes no strobe
  a_r5_prefix_silent: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && is_pfx) |=> !move_valid);

  // R9: an accepted ordinary word is strobed next cycle
  a_r9_strobe_follows: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !is_pfx) |=> move_valid);

  // R8: no strobe after an idle cycle
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> !move_valid);

  // R2: immediate format and byte reach the outputs
  a_r2_imm_source: assert property (@(posedge clk) disable iff (rst)
    (move_take && !instr[INSTR_W-1]) |=>
      (src_is_imm && src_imm == $past(instr[IMM_W-1:0])));

  // R4: no prefix pending leaves upper destination bits clear
  a_r4_no_prefix_upper: assert property (@(posedge clk) disable iff (rst)
    (move_take && pfx_q == '0) |=> (dst_idx[DIDX_W-1:SUB_W] == '0));
endmodule

// File: tb/test_move_decoder.sv
module test_move_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [15:0] instr = '0;
  logic        move_valid, src_is_imm;
  logic [7:0]  src_imm;
  logic [3:0]  src_mod, src_idx, dst_mod;
  logic [4:0]  dst_idx;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  move_decoder i_move_decoder (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .move_valid(move_valid), .src_is_imm(src_is_imm), .src_imm(src_imm),
    .src_mod(src_mod), .src_idx(src_idx), .dst_mod(dst_mod), .dst_idx(dst_idx)
  );

  // vector: instr, valid, is_imm, imm, smod, sidx, dmod, didx (43 bits)
  localparam int NV = 11;
  localparam logic [42:0] VEC [NV] = '{
    {16'h53A7, 1'b1, 1'b1, 8'hA7, 4'h7, 4'hA, 4'h3, 5'd5},   // R2 R4
    {16'hAC4E, 1'b1, 1'b0, 8'h4E, 4'hE, 4'h4, 4'hC, 5'd2},   // R3
    {16'h0B03, 1'b0, 1'b0, 8'h00, 4'h0, 4'h0, 4'h0, 5'd0},   // R5 prefix 3
    {16'h7F12, 1'b1, 1'b1, 8'h12, 4'h2, 4'h1, 4'hF, 5'd31},  // R6
    {16'h7F12, 1'b1, 1'b1, 8'h12, 4'h2, 4'h1, 4'hF, 5'd7},   // R6 cleared
    {16'h0B01, 1'b0, 1'b0, 8'h00, 4'h0, 4'h0, 4'h0, 5'd0},   // R7 first
    {16'h0B02, 1'b0, 1'b0, 8'h00, 4'h0, 4'h0, 4'h0, 5'd0},   // R7 second
    {16'h9165, 1'b1, 1'b0, 8'h65, 4'h5, 4'h6, 4'h1, 5'd17},  // R7 later wins
    {16'h9165, 1'b1, 1'b0, 8'h65, 4'h5, 4'h6, 4'h1, 5'd1},   // R6
    {16'h8B01, 1'b0, 1'b0, 8'h00, 4'h0, 4'h0, 4'h0, 5'd0},   // R5 register format
    {16'h0000, 1'b1, 1'b1, 8'h00, 4'h0, 4'h0, 4'h0, 5'd8}    // R5 R9
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(logic v, logic [15:0] w);
    @(negedge clk);
    instr_valid = v;
    instr = w;
    @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    if (!done && $time > 400000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 move_valid", move_valid, 0);
    chk("R1 dst_idx", dst_idx, 0);
    chk("R1 src_imm", src_imm, 0);
    @(negedge clk) rst = 1'b0;

    // vector table, back-to-back words
    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i][42:27]);
      chk("R9 move_valid", move_valid, VEC[i][26]);
      if (VEC[i][26]) begin
        chk("R2/R3 src_is_imm", src_is_imm, VEC[i][25]);
        chk("R3 src_imm", src_imm, VEC[i][24:17]);
        chk("R3 src_mod", src_mod, VEC[i][16:13]);
        chk("R3 src_idx", src_idx, VEC[i][12:9]);
        chk("R4 dst_mod", dst_mod, VEC[i][8:5]);
        chk("R4/R6 dst_idx", dst_idx, VEC[i][4:0]);
      end
    end
    // R9: single-cycle pulse
    drive(1'b0, 16'h0000);
    chk("R9 pulse ends", move_valid, 0);

    // R8: prefix survives idle cycles
    drive(1'b1, 16'h0B03);
    for (int k = 0; k < 3; k++) begin
      drive(1'b0, 16'h0400);
      chk("R8 idle no strobe", move_valid, 0);
    end
    drive(1'b1, 16'h0400);
    chk("R8 strobe", move_valid, 1);
    chk("R8 prefix kept", dst_idx, 24);
    chk("R4 dst_mod", dst_mod, 4);

    // R1: reset discards pending prefix
    drive(1'b1, 16'h0B02);
    @(negedge clk);
    instr_valid = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R1 reset move_valid", move_valid, 0);
    chk("R1 reset dst_mod", dst_mod, 0);
    @(negedge clk) rst = 1'b0;
    drive(1'b1, 16'h0400);
    chk("R1 prefix discarded", dst_idx, 0);
    drive(1'b0, 16'h0000);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule